// File: doc/BRIEF.md
# Instruction Cache Tag Simulator

This block models the timing of a set-associative instruction cache without holding any instruction bytes. It keeps, for every set, a tag and a valid bit per way and a replacement pointer, and it charges a fixed number of penalty cycles into a running correction counter whenever a lookup misses. Cache data, refill traffic and coherence are not modelled.

A request names one tag and a span of set indices, from a first index to a last index. The span stands for a straight run of instructions that share a tag and cross one or more cache lines. After accepting a request, the block visits one set per clock from the first index to the last. It checks each set for the tag and updates the replacement pointer. On a miss it installs the tag and adds the penalty. When the span is finished, it pulses `done` with the number of hits and misses seen.

The control is a three-state machine. **ST_IDLE** accepts a request (transition *accept*: `req_valid` while idle). **ST_WALK** visits one set per clock. It moves on to the next index (*advance*), holds the same index during a flush (*stall*), and leaves after the last index (*finish*). **ST_REPORT** drives the single-cycle `done` pulse and then returns to ST_IDLE (*release*).

Top module: `icache_tag_sim`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0, `acc_cycles` is 0 and no way of any set holds a valid tag, so the first lookup anywhere misses.
- R2: A lookup hits only when one way of the visited set is valid and its stored tag equals the request tag. A hit adds nothing to `acc_cycles`.
- R3: A lookup that misses adds MISS_PENALTY (default 4) to `acc_cycles`, writes the request tag into the victim way and marks that way valid, so a repeat lookup of the same tag in that set hits.
- R4: With two ways, each set keeps a one-bit victim pointer that is 0 after reset. A miss fills the way the pointer names, and after any hit or fill of way w the pointer names the other way.
- R5: A request visits indices first, first+1, … up to last inclusive, one per clock, wrapping from SETS-1 to 0 when first > last, and touches no other set. `req_ready` is 0 from the accepting edge until `done` has been shown. For a span of n sets with no flush, `done` is 1 at the (n+1)-th falling edge after the accepting rising edge.
- R6: `done` is high for exactly one cycle. While it is high, `done_hits` and `done_misses` hold the hit and miss counts of the request just finished.
- R7: `flush` clears every valid bit and every victim pointer at the next edge. If `flush` is high during a walk, it wins over that cycle's lookup: the current index is held and looked up again on the following cycle, and that repeat lookup misses.
- R8: `acc_clear` sets `acc_cycles` to 0 at the next edge. A miss penalty charged on the same edge still counts, so the result equals MISS_PENALTY.
- R9: `acc_cycles` saturates at 2^ACC_W-1 and does not wrap.
- R10: `req_valid` is ignored while `req_ready` is 0: such a request is neither queued nor looked up, and the tag it carries is not installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of all valid bits and victim pointers |
| acc_clear | input | 1 | Synchronous clear of the penalty accumulator |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_tag | input | TAG_W | Tag looked up in every set of the span |
| req_first | input | log2(SETS) | First set index of the span |
| req_last | input | log2(SETS) | Last set index of the span |
| done | output | 1 | One-cycle pulse after the last set of a span |
| done_hits | output | log2(SETS+1) | Hits in the finished request |
| done_misses | output | log2(SETS+1) | Misses in the finished request |
| acc_cycles | output | ACC_W | Accumulated miss-penalty cycles |

## Verification
The embedded assertions watch four things on every cycle. The accumulator may only stay the same, grow by exactly one penalty, or sit at saturation when it is not being cleared. No two ways of a set ever match the same tag. A lookup on the cycle after a flush never hits. The hit and miss counts shown with `done` always add up to the length of the wrapped span. The directed scenarios are what show the choices themselves: which way a miss replaces, which sets a wrapped span touches, how long a walk lasts when a flush stalls it, what a clear does when it meets a penalty, and that a request offered while busy leaves no trace.

// File: rtl/icts_pkg.sv
package icts_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WALK   = 2'd1,
        ST_REPORT = 2'd2
    } icts_state_e;

endpackage

// File: rtl/icts_tag_array.sv
module icts_tag_array #(
    parameter int WAYS  = 2,
    parameter int SETS  = 8,
    parameter int TAG_W = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [WAYS*TAG_W-1:0]   rd_tags,
    output logic [WAYS-1:0]         rd_valid,
    output logic [WAY_W-1:0]        rd_victim,
    input  logic                    upd_en,
    input  logic                    upd_fill,
    input  logic [WAY_W-1:0]        upd_way,
    input  logic [TAG_W-1:0]        upd_tag
);

    // Per-way storage: tag and valid bit for every set
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        logic [TAG_W-1:0] tag_mem [SETS];
        logic [SETS-1:0]  vld_mem;
        logic             wr_here;

        assign wr_here = upd_en && upd_fill && (upd_way == WAY_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                vld_mem <= '0;
            else if (flush)
                vld_mem <= '0;
            else if (wr_here)
                vld_mem[rd_idx] <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (!flush && wr_here)
                tag_mem[rd_idx] <= upd_tag;
        end

        assign rd_tags[g*TAG_W +: TAG_W] = tag_mem[rd_idx];
        assign rd_valid[g]               = vld_mem[rd_idx];
    end

    // Victim pointer per set: after touching way w, point past it
    logic [WAY_W-1:0] ptr_mem [SETS];
    logic [WAY_W-1:0] ptr_next;

    always_comb begin
        if (upd_way == WAY_W'(WAYS - 1))
            ptr_next = '0;
        else
            ptr_next = upd_way + WAY_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ptr_mem[s] <= '0;
        end else if (flush) begin
            for (int s = 0; s < SETS; s++) ptr_mem[s] <= '0;
        end else if (upd_en) begin
            ptr_mem[rd_idx] <= ptr_next;
        end
    end

    assign rd_victim = ptr_mem[rd_idx];

endmodule

// File: rtl/icts_lookup.sv
module icts_lookup #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS*TAG_W-1:0] rd_tags,
    input  logic [WAYS-1:0]       rd_valid,
    input  logic [WAY_W-1:0]      rd_victim,
    input  logic [TAG_W-1:0]      req_tag,
    output logic [WAYS-1:0]       match,
    output logic                  hit,
    output logic [WAY_W-1:0]      sel_way
);

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = rd_valid[g] && (rd_tags[g*TAG_W +: TAG_W] == req_tag);
    end

    logic [WAY_W-1:0] hit_way;

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit     = |match;
    assign sel_way = hit ? hit_way : rd_victim;

endmodule

// File: rtl/icache_tag_sim.sv
module icache_tag_sim
    import icts_pkg::*;
#(
    parameter int WAYS         = 2,
    parameter int SETS         = 8,
    parameter int TAG_W        = 4,
    parameter int MISS_PENALTY = 4,
    parameter int ACC_W        = 16,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int CNT_W = $clog2(SETS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             acc_clear,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [IDX_W-1:0] req_first,
    input  logic [IDX_W-1:0] req_last,
    output logic             done,
    output logic [CNT_W-1:0] done_hits,
    output logic [CNT_W-1:0] done_misses,
    output logic [ACC_W-1:0] acc_cycles
);

    localparam logic [ACC_W:0]   PEN_EXT = (ACC_W + 1)'(MISS_PENALTY);
    localparam logic [ACC_W-1:0] ACC_MAX = '1;

    icts_state_e state_q, state_d;

    logic [TAG_W-1:0] tag_q;
    logic [IDX_W-1:0] cur_q, first_q, last_q;
    logic [CNT_W-1:0] hits_q, miss_q;
    logic [ACC_W-1:0] acc_q;

    logic [WAYS*TAG_W-1:0] rd_tags;
    logic [WAYS-1:0]       rd_valid, lk_match;
    logic [WAY_W-1:0]      rd_victim, sel_way;
    logic                  lk_hit;

    logic accept, step, at_last;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign step    = (state_q == ST_WALK) && !flush;
    assign at_last = (cur_q == last_q);

    icts_tag_array #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .rd_idx   (cur_q),
        .rd_tags  (rd_tags),
        .rd_valid (rd_valid),
        .rd_victim(rd_victim),
        .upd_en   (step),
        .upd_fill (!lk_hit),
        .upd_way  (sel_way),
        .upd_tag  (tag_q)
    );

    icts_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
        .rd_tags  (rd_tags),
        .rd_valid (rd_valid),
        .rd_victim(rd_victim),
        .req_tag  (tag_q),
        .match    (lk_match),
        .hit      (lk_hit),
        .sel_way  (sel_way)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: accept, advance/stall, finish, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid)         state_d = ST_WALK;
            ST_WALK:   if (step && at_last)   state_d = ST_REPORT;
            ST_REPORT:                        state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        req_ready = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_WALK:   ;
            ST_REPORT: done      = 1'b1;
            default:   ;
        endcase
    end

    // Request datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q   <= '0;
            cur_q   <= '0;
            first_q <= '0;
            last_q  <= '0;
            hits_q  <= '0;
            miss_q  <= '0;
        end else if (accept) begin
            tag_q   <= req_tag;
            cur_q   <= req_first;
            first_q <= req_first;
            last_q  <= req_last;
            hits_q  <= '0;
            miss_q  <= '0;
        end else if (step) begin
            cur_q <= cur_q + IDX_W'(1);
            if (lk_hit) hits_q <= hits_q + CNT_W'(1);
            else        miss_q <= miss_q + CNT_W'(1);
        end
    end

    // Penalty accumulator with clear and saturation
    logic [ACC_W:0] acc_sum;

    always_comb begin
        acc_sum = acc_clear ? '0 : {1'b0, acc_q};
        if (step && !lk_hit) acc_sum = acc_sum + PEN_EXT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          acc_q <= '0;
        else if (acc_sum[ACC_W]) acc_q <= ACC_MAX;
        else                 acc_q <= acc_sum[ACC_W-1:0];
    end

    assign acc_cycles  = acc_q;
    assign done_hits   = hits_q;
    assign done_misses = miss_q;

    // Assertions
    logic [CNT_W:0] span_len;
    assign span_len = (CNT_W + 1)'(IDX_W'(last_q - first_q)) + (CNT_W + 1)'(1);

    AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_clear |=> (acc_cycles == $past(acc_cycles))
                    || ({1'b0, acc_cycles} == {1'b0, $past(acc_cycles)} + PEN_EXT)
                    || (acc_cycles == ACC_MAX)); // R3

    AST_NO_DUP_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WALK) |-> $onehot0(lk_match)); // R2

    AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit); // R7

    AST_DONE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((CNT_W + 1)'(done_hits) + (CNT_W + 1)'(done_misses) == span_len)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R5

endmodule

// File: tb/icache_tag_sim_test.sv
module icache_tag_sim_test;

    localparam int TAG_W = 4;
    localparam int IDX_W = 3;
    localparam int CNT_W = 4;
    localparam int ACC_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             flush = 1'b0;
    logic             acc_clear = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [TAG_W-1:0] req_tag = '0;
    logic [IDX_W-1:0] req_first = '0;
    logic [IDX_W-1:0] req_last = '0;
    logic             done;
    logic [CNT_W-1:0] done_hits, done_misses;
    logic [ACC_W-1:0] acc_cycles;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    icache_tag_sim #(.WAYS(2), .SETS(8), .TAG_W(TAG_W), .MISS_PENALTY(4), .ACC_W(ACC_W)) uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .acc_clear(acc_clear),
        .req_valid(req_valid), .req_ready(req_ready), .req_tag(req_tag),
        .req_first(req_first), .req_last(req_last), .done(done),
        .done_hits(done_hits), .done_misses(done_misses), .acc_cycles(acc_cycles)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clean();
        @(negedge clk);
        flush = 1'b1; acc_clear = 1'b1;
        @(negedge clk);
        flush = 1'b0; acc_clear = 1'b0;
    endtask

    // Issue one request and wait for done; cycles counts falling edges from acceptance
    task automatic do_req(input int tag, input int first, input int last,
                          output int hits, output int misses, output int cycles,
                          output int ready_seen);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_tag = TAG_W'(tag);
        req_first = IDX_W'(first); req_last = IDX_W'(last);
        @(negedge clk);
        req_valid = 1'b0;
        cycles = 1; ready_seen = 0;
        while (!done) begin
            if (req_ready) ready_seen = 1;
            @(negedge clk);
            cycles++;
        end
        if (req_ready) ready_seen = 1;
        hits = done_hits; misses = done_misses;
    endtask

    task automatic single(input string req, input int tag, input int idx, input int exp_hit);
        int h, m, c, r;
        do_req(tag, idx, idx, h, m, c, r);
        check(req, h, exp_hit);
        check(req, m, 1 - exp_hit);
    endtask

    task automatic t_reset();
        int h, m, c, r;
        check("R1 ready", req_ready, 1);
        check("R1 done", done, 0);
        check("R1 acc", acc_cycles, 0);
        do_req(3, 0, 0, h, m, c, r);
        check("R1 first lookup misses", m, 1);
    endtask

    task automatic t_hit_miss();
        int h, m, c, r;
        clean();
        do_req(2, 0, 3, h, m, c, r);
        check("R3 cold misses", m, 4);
        check("R3 penalty", acc_cycles, 16);
        do_req(2, 0, 3, h, m, c, r);
        check("R2 warm hits", h, 4);
        check("R2 hit adds nothing", acc_cycles, 16);
        do_req(3, 0, 1, h, m, c, r);
        check("R2 other tag misses", m, 2);
        check("R3 penalty again", acc_cycles, 24);
    endtask

    task automatic t_lru();
        clean();
        single("R4 A fill way0", 1, 5, 0);
        single("R4 B fill way1", 2, 5, 0);
        single("R4 A hit", 1, 5, 1);
        single("R4 C evicts B", 3, 5, 0);
        single("R4 A still present", 1, 5, 1);
        single("R4 B was evicted", 2, 5, 0);
        single("R4 C evicted by B", 3, 5, 0);
        single("R4 A evicted by C", 1, 5, 0);
    endtask

    task automatic t_range();
        int h, m, c, r;
        clean();
        do_req(6, 2, 2, h, m, c, r);
        check("R5 one-set latency", c, 2);
        check("R5 ready low while busy", r, 0);
        do_req(7, 6, 1, h, m, c, r);
        check("R5 wrapped span misses", m, 4);
        check("R5 wrapped span latency", c, 5);
        check("R6 misses shown with done", done_misses, 4);
        @(negedge clk);
        check("R6 done single cycle", done, 0);
        check("R5 ready back", req_ready, 1);
        single("R5 index 0 visited", 7, 0, 1);
        single("R5 index 7 visited", 7, 7, 1);
        single("R5 index 5 untouched", 7, 5, 0);
    endtask

    task automatic t_flush();
        int h, m, c, r;
        clean();
        do_req(5, 0, 3, h, m, c, r);
        @(negedge clk);
        req_valid = 1'b1; req_tag = 4'd5; req_first = 3'd0; req_last = 3'd3;
        @(negedge clk);
        req_valid = 1'b0; c = 1;
        @(negedge clk); c++;
        flush = 1'b1;
        @(negedge clk); c++;
        flush = 1'b0;
        while (!done) begin @(negedge clk); c++; end
        check("R7 hits before flush", done_hits, 1);
        check("R7 misses after flush", done_misses, 3);
        check("R7 stall adds a cycle", c, 6);
        check("R7 penalty total", acc_cycles, 28);
        single("R7 flush cleared earlier set", 5, 0, 0);
    endtask

    task automatic t_clear();
        int h, m, c, r;
        clean();
        do_req(1, 0, 1, h, m, c, r);
        check("R8 before clear", acc_cycles, 8);
        @(negedge clk);
        req_valid = 1'b1; req_tag = 4'd2; req_first = 3'd3; req_last = 3'd3;
        @(negedge clk);
        req_valid = 1'b0; acc_clear = 1'b1;
        @(negedge clk);
        acc_clear = 1'b0;
        check("R8 clear keeps same-cycle penalty", acc_cycles, 4);
        while (!done) @(negedge clk);
        @(negedge clk);
        acc_clear = 1'b1;
        @(negedge clk);
        acc_clear = 1'b0;
        check("R8 idle clear", acc_cycles, 0);
    endtask

    task automatic t_ignore();
        clean();
        @(negedge clk);
        req_valid = 1'b1; req_tag = 4'd4; req_first = 3'd0; req_last = 3'd2;
        @(negedge clk);
        req_tag = 4'd9; req_first = 3'd7; req_last = 3'd7;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        check("R10 only first request counted", done_misses, 3);
        @(negedge clk);
        check("R10 no queued request", req_ready, 1);
        @(negedge clk);
        check("R10 still idle", req_ready, 1);
        check("R10 accumulator", acc_cycles, 12);
        single("R10 ignored tag not installed", 9, 7, 0);
    endtask

    task automatic t_sat();
        int h, m, c, r;
        clean();
        do_req(1, 0, 7, h, m, c, r);
        check("R9 below limit", acc_cycles, 32);
        do_req(2, 0, 7, h, m, c, r);
        check("R9 saturates", acc_cycles, 63);
        do_req(3, 0, 0, h, m, c, r);
        check("R9 stays saturated", acc_cycles, 63);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hit_miss();
        t_lru();
        t_range();
        t_flush();
        t_clear();
        t_ignore();
        t_sat();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule